// File: doc/BRIEF.md
# Per-Bank DRAM Power-Down State Manager

This block keeps the low-power state of every bank of a DRAM device and decides when each bank should enter or leave a power-down mode. It counts outstanding transactions per bank. When a bank's count falls to zero, the block tries to put that bank to sleep. The kind of power-down it picks depends on whether a row is open. A bank that then stays idle long enough is moved on to self-refresh. When a new request or a refresh trigger reaches a sleeping bank, the block wakes it with the matching exit command.

Entry and exit commands leave the block on a valid/ready stream toward the command timing checker. Once `cmd_valid` is high, bank and opcode hold steady until `cmd_ready` is seen at a clock edge. The checker may stall for any number of cycles. While it stalls, events for other banks are still accepted and queued, one command slot per bank plus one follow-up slot.

The refresh scheduler is reached through plain control pins. It flags a pending-refresh collision per bank, and it receives a one-cycle pulse when its timer for a bank must restart because that bank has finished leaving self-refresh.

Top module: `pdm_power_mgr`

## Requirements
- R1: After reset, every bank reports state 0 (awake), `bank_awake` is all ones, `cmd_valid` is low and `rfsh_reinit` is all zeros.
- R2: A done event that brings a bank's outstanding count to zero is a sleep attempt. It succeeds only when the bank is awake with no command queued. The bank then moves to state 2 (active power-down) and emits op 0 if `row_open` is high for it. If `row_open` is low, it moves to state 3 (precharge power-down) and emits op 1.
- R3: If `rfsh_collide` is high for the bank during a sleep attempt, the state stays unchanged and no command is emitted.
- R4: A bank that has been in state 2 or 3 for IDLE_SR_CYC consecutive cycles, with its entry command already accepted and nothing queued, moves to state 4 (self-refresh) and emits op 2. This move ignores `rfsh_collide`.
- R5: A request for a bank in state 1 (awake for refresh) returns it to state 0 without any command.
- R6: A request for a bank in state 2, 3 or 4 moves it to state 0 and emits the matching exit: op 3, 4 or 5 respectively.
- R7: A refresh trigger for a bank in state 2, 3 or 4 emits the matching exit (op 3, 4 or 5) and moves the bank to state 1. A refresh trigger for an awake bank has no effect.
- R8: When an op 5 (self-refresh exit) command is accepted in cycle T, `rfsh_reinit` for that bank is high for exactly one cycle, cycle T+SRX_CYC.
- R9: `bank_awake` for a bank is low while the bank is in state 2, 3 or 4, or has an exit queued. It goes high only once the bank is physically out of power-down.
- R10: The command stream holds `cmd_valid`, `cmd_bank` and `cmd_op` steady while stalled. Among banks with a queued command, the lowest-numbered bank is offered first.
- R11: A wake (request or refresh trigger) that reaches a bank whose entry command has not yet been offered withdraws that entry. No command is sent for it, and the bank is left awake.
- R12: A wake that reaches a bank whose entry command is being offered under back-pressure does not withdraw it. The entry is sent, and the matching exit follows immediately after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New request arrives for `req_bank` |
| req_bank | input | BW | Bank of the arriving request |
| done_valid | input | 1 | Transaction leaves for `done_bank` |
| done_bank | input | BW | Bank of the finished transaction |
| rfsh_hit_valid | input | 1 | Refresh trigger for `rfsh_hit_bank` |
| rfsh_hit_bank | input | BW | Bank hit by the refresh trigger |
| row_open | input | NB | Per-bank: a row is open |
| rfsh_collide | input | NB | Per-bank: an entry now would collide with a pending refresh |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Command accepted by the timing checker |
| cmd_bank | output | BW | Bank of the offered command |
| cmd_op | output | 3 | 0/1/2 enter active/precharge/self-refresh; 3/4/5 the matching exits |
| bank_state | output | 3*NB | Per-bank state, bank b in bits [3b+2:3b] |
| bank_awake | output | NB | Per-bank: awake and safe for the scheduler's busy check |
| rfsh_reinit | output | NB | Per-bank one-cycle refresh-timer restart pulse |

## Verification
The assertions watch the following on every cycle:
- stream stability under stall;
- a queued exit is only accepted once the bank's state has already turned awake;
- a sleeping bank never reports `bank_awake`;
- self-refresh is left only toward an awake state;
- an awake bank never jumps straight to self-refresh or awake-for-refresh;
- the timer-restart pulse never lasts two cycles.

Only the bench's scenarios can show the rest:
- which flavour of power-down gets picked;
- the collision veto;
- the exact cycle counts of idle escalation and of the restart pulse;
- withdrawal of an entry that was never offered, versus queuing behind one already offered.

In its random phase the bench tracks the physical mode of each bank from the accepted commands alone, and checks every command and every `bank_awake` against it.

// File: rtl/pdm_pkg.sv
package pdm_pkg;

  typedef enum logic [2:0] {
    ST_AWAKE    = 3'd0,
    ST_AWAKE_RF = 3'd1,
    ST_PD_ACT   = 3'd2,
    ST_PD_PRE   = 3'd3,
    ST_SELF_RF  = 3'd4
  } bank_st_t;

  typedef enum logic [2:0] {
    OP_ENT_ACT = 3'd0,
    OP_ENT_PRE = 3'd1,
    OP_ENT_SR  = 3'd2,
    OP_EXT_ACT = 3'd3,
    OP_EXT_PRE = 3'd4,
    OP_EXT_SR  = 3'd5
  } pd_op_t;

  function automatic logic op_is_entry(pd_op_t o);
    return (o == OP_ENT_ACT) || (o == OP_ENT_PRE) || (o == OP_ENT_SR);
  endfunction

  function automatic logic st_is_down(bank_st_t s);
    return (s == ST_PD_ACT) || (s == ST_PD_PRE) || (s == ST_SELF_RF);
  endfunction

  function automatic pd_op_t exit_for(bank_st_t s);
    case (s)
      ST_PD_ACT: return OP_EXT_ACT;
      ST_PD_PRE: return OP_EXT_PRE;
      default:   return OP_EXT_SR;
    endcase
  endfunction

endpackage

// File: rtl/pdm_bank.sv
module pdm_bank
  import pdm_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int IDLE_SR_CYC = 8,
  parameter int SRX_CYC     = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ev_req,
  input  logic     ev_ref,
  input  logic     ev_done,
  input  logic     collide,
  input  logic     row_open,
  input  logic     offer,
  input  logic     grant,
  output bank_st_t state_o,
  output logic     pend_v_o,
  output pd_op_t   pend_op_o,
  output logic     awake_o,
  output logic     reinit_o
);

  localparam int IDW = $clog2(IDLE_SR_CYC + 1);
  localparam int SXW = $clog2(SRX_CYC + 1);
  localparam logic [IDW-1:0] IDLE_LAST = IDW'(IDLE_SR_CYC - 1);
  localparam logic [SXW-1:0] SRX_LOAD  = SXW'(SRX_CYC - 1);

  bank_st_t         st_q, st_n, prev_q, prev_n, eff;
  logic             pv_q, pv_n, fv_q, fv_n;
  pd_op_t           po_q, po_n, fo_q, fo_n, wop;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [IDW-1:0]   idle_q, idle_n;
  logic [SXW-1:0]   srx_q;
  logic             srx_run_q;
  logic             live, busy, want, sleep_try, idle_on, idle_hit;

  assign cnt_n    = cnt_q + CNT_W'(ev_req) - CNT_W'(ev_done);
  // an entry that was queued but never shown on the stream may be withdrawn
  assign live     = pv_q && op_is_entry(po_q) && !offer;
  assign eff      = live ? prev_q : st_q;
  assign idle_on  = (st_q == ST_PD_ACT || st_q == ST_PD_PRE) && !pv_q && !fv_q;
  assign idle_hit = idle_on && (idle_q == IDLE_LAST);
  assign sleep_try = ev_done && (cnt_n == '0) && (st_q == ST_AWAKE) && !pv_q && !fv_q;
  assign busy     = pv_q && !grant && !live;

  always_comb begin
    st_n   = st_q;
    prev_n = prev_q;
    pv_n   = pv_q && !grant;
    po_n   = po_q;
    fv_n   = fv_q;
    fo_n   = fo_q;
    want   = 1'b0;
    wop    = OP_EXT_SR;
    if (grant && fv_q) begin
      pv_n = 1'b1;
      po_n = fo_q;
      fv_n = 1'b0;
    end
    if (live && (ev_req || ev_ref)) pv_n = 1'b0;
    if (ev_req) begin
      st_n = ST_AWAKE;
      if (st_is_down(eff)) begin
        want = 1'b1;
        wop  = exit_for(eff);
      end
    end else if (ev_ref) begin
      if (st_is_down(eff)) begin
        st_n = ST_AWAKE_RF;
        want = 1'b1;
        wop  = exit_for(eff);
      end else begin
        st_n = eff;
      end
    end else if (sleep_try && !collide) begin
      prev_n = st_q;
      st_n   = row_open ? ST_PD_ACT : ST_PD_PRE;
      want   = 1'b1;
      wop    = row_open ? OP_ENT_ACT : OP_ENT_PRE;
    end else if (idle_hit) begin
      prev_n = st_q;
      st_n   = ST_SELF_RF;
      want   = 1'b1;
      wop    = OP_ENT_SR;
    end
    if (want) begin
      if (busy) begin
        fv_n = 1'b1;
        fo_n = wop;
      end else begin
        pv_n = 1'b1;
        po_n = wop;
      end
    end
  end

  assign idle_n = (idle_on && !idle_hit) ? idle_q + 1'b1 : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_AWAKE;
      prev_q    <= ST_AWAKE;
      pv_q      <= 1'b0;
      po_q      <= OP_ENT_ACT;
      fv_q      <= 1'b0;
      fo_q      <= OP_ENT_ACT;
      cnt_q     <= '0;
      idle_q    <= '0;
      srx_q     <= '0;
      srx_run_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      prev_q <= prev_n;
      pv_q   <= pv_n;
      po_q   <= po_n;
      fv_q   <= fv_n;
      fo_q   <= fo_n;
      cnt_q  <= cnt_n;
      idle_q <= idle_n;
      if (grant && po_q == OP_EXT_SR) begin
        srx_run_q <= 1'b1;
        srx_q     <= SRX_LOAD;
      end else if (srx_run_q) begin
        if (srx_q == '0) srx_run_q <= 1'b0;
        else             srx_q     <= srx_q - 1'b1;
      end
    end
  end

  assign state_o   = st_q;
  assign pend_v_o  = pv_q;
  assign pend_op_o = po_q;
  assign awake_o   = !st_is_down(st_q) && !(pv_q && !op_is_entry(po_q)) && !fv_q;
  assign reinit_o  = srx_run_q && (srx_q == '0);

endmodule

// File: rtl/pdm_cmd_arb.sv
module pdm_cmd_arb
  import pdm_pkg::*;
#(
  parameter  int NB = 4,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NB-1:0]      pend_v,
  input  pd_op_t [NB-1:0]    pend_op,
  input  logic               cmd_ready,
  output logic               cmd_valid,
  output logic [BW-1:0]      cmd_bank,
  output pd_op_t             cmd_op,
  output logic [NB-1:0]      offer,
  output logic [NB-1:0]      grant
);

  logic          lock_q, any;
  logic [BW-1:0] held_q, pick, sel;

  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int b = NB - 1; b >= 0; b--) begin
      if (pend_v[b]) begin
        pick = BW'(b);
        any  = 1'b1;
      end
    end
  end

  assign sel       = lock_q ? held_q : pick;
  assign cmd_valid = lock_q || any;
  assign cmd_bank  = sel;
  assign cmd_op    = pend_op[sel];

  for (genvar b = 0; b < NB; b++) begin : g_hs
    assign offer[b] = cmd_valid && (sel == BW'(b));
    assign grant[b] = offer[b] && cmd_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      held_q <= '0;
    end else begin
      lock_q <= cmd_valid && !cmd_ready;
      held_q <= sel;
    end
  end

endmodule

// File: rtl/pdm_power_mgr.sv
module pdm_power_mgr
  import pdm_pkg::*;
#(
  parameter  int NB          = 4,
  parameter  int CNT_W       = 4,
  parameter  int IDLE_SR_CYC = 8,
  parameter  int SRX_CYC     = 4,
  localparam int BW          = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [BW-1:0]     req_bank,
  input  logic              done_valid,
  input  logic [BW-1:0]     done_bank,
  input  logic              rfsh_hit_valid,
  input  logic [BW-1:0]     rfsh_hit_bank,
  input  logic [NB-1:0]     row_open,
  input  logic [NB-1:0]     rfsh_collide,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [BW-1:0]     cmd_bank,
  output logic [2:0]        cmd_op,
  output logic [3*NB-1:0]   bank_state,
  output logic [NB-1:0]     bank_awake,
  output logic [NB-1:0]     rfsh_reinit
);

  logic [NB-1:0]   pend_v, offer, grant;
  pd_op_t [NB-1:0] pend_op;
  pd_op_t          op_sel;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    bank_st_t st_b;
    pdm_bank #(
      .CNT_W(CNT_W), .IDLE_SR_CYC(IDLE_SR_CYC), .SRX_CYC(SRX_CYC)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_req   (req_valid && (req_bank == BW'(b))),
      .ev_ref   (rfsh_hit_valid && (rfsh_hit_bank == BW'(b))),
      .ev_done  (done_valid && (done_bank == BW'(b))),
      .collide  (rfsh_collide[b]),
      .row_open (row_open[b]),
      .offer    (offer[b]),
      .grant    (grant[b]),
      .state_o  (st_b),
      .pend_v_o (pend_v[b]),
      .pend_op_o(pend_op[b]),
      .awake_o  (bank_awake[b]),
      .reinit_o (rfsh_reinit[b])
    );
    assign bank_state[3*b +: 3] = st_b;
  end

  pdm_cmd_arb #(.NB(NB)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend_v   (pend_v),
    .pend_op  (pend_op),
    .cmd_ready(cmd_ready),
    .cmd_valid(cmd_valid),
    .cmd_bank (cmd_bank),
    .cmd_op   (op_sel),
    .offer    (offer),
    .grant    (grant)
  );

  assign cmd_op = op_sel;

endmodule

// File: rtl/pdm_power_mgr_chk.sv
module pdm_power_mgr_chk #(
  parameter int NB = 4,
  parameter int BW = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic [BW-1:0]   cmd_bank,
  input logic [2:0]      cmd_op,
  input logic [3*NB-1:0] bank_state,
  input logic [NB-1:0]   bank_awake,
  input logic [NB-1:0]   rfsh_reinit
);

  // R10
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_bank) && $stable(cmd_op));

  // R6
  exit_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && (cmd_op >= 3'd3) |-> bank_state[int'(cmd_bank)*3 +: 3] <= 3'd1);

  for (genvar b = 0; b < NB; b++) begin : g_chk
    logic [2:0] s;
    assign s = bank_state[3*b +: 3];

    // R9
    down_not_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s >= 3'd2) |-> !bank_awake[b]);

    // R4
    sr_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(s) == 3'd4 && s != 3'd4 |-> s <= 3'd1);

    // R2
    awake_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s == 3'd0 |=> s == 3'd0 || s == 3'd2 || s == 3'd3);

    // R8
    reinit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rfsh_reinit[b] |=> !rfsh_reinit[b]);
  end

endmodule

bind pdm_power_mgr pdm_power_mgr_chk #(.NB(NB), .BW(BW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_bank   (cmd_bank),
  .cmd_op     (cmd_op),
  .bank_state (bank_state),
  .bank_awake (bank_awake),
  .rfsh_reinit(rfsh_reinit)
);

// File: tb/test_pdm_power_mgr.sv
module test_pdm_power_mgr;

  localparam int NB = 4;
  localparam int BW = 2;
  localparam int IDLE = 8;
  localparam int SRX = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, done_valid, rfsh_hit_valid, cmd_ready;
  logic [BW-1:0] req_bank, done_bank, rfsh_hit_bank;
  logic [NB-1:0] row_open, rfsh_collide;
  logic cmd_valid;
  logic [BW-1:0] cmd_bank;
  logic [2:0] cmd_op;
  logic [3*NB-1:0] bank_state;
  logic [NB-1:0] bank_awake, rfsh_reinit;

  int n_checks = 0;
  int n_fail = 0;
  int phys[NB];
  int outst[NB];

  always #5 clk = ~clk;

  pdm_power_mgr #(.NB(NB), .CNT_W(4), .IDLE_SR_CYC(IDLE), .SRX_CYC(SRX)) i_pdm_power_mgr (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_bank(req_bank),
    .done_valid(done_valid), .done_bank(done_bank),
    .rfsh_hit_valid(rfsh_hit_valid), .rfsh_hit_bank(rfsh_hit_bank),
    .row_open(row_open), .rfsh_collide(rfsh_collide),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_bank(cmd_bank), .cmd_op(cmd_op),
    .bank_state(bank_state), .bank_awake(bank_awake), .rfsh_reinit(rfsh_reinit)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int st_of(input int b);
    return int'(bank_state[b*3 +: 3]);
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ev_req(input int b);
    req_valid = 1'b1; req_bank = BW'(b);
    tick();
    req_valid = 1'b0;
  endtask

  task automatic ev_done(input int b);
    done_valid = 1'b1; done_bank = BW'(b);
    tick();
    done_valid = 1'b0;
  endtask

  task automatic ev_ref(input int b);
    rfsh_hit_valid = 1'b1; rfsh_hit_bank = BW'(b);
    tick();
    rfsh_hit_valid = 1'b0;
  endtask

  task automatic cmd_is(input string tag, input int b, input int op);
    check({tag, " valid"}, int'(cmd_valid), 1);
    check({tag, " bank"}, int'(cmd_bank), b);
    check({tag, " op"}, int'(cmd_op), op);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    int seed_d;
    int pv, pr, pb, po;
    seed_d = int'($urandom(32'd24681));
    rst_n = 1'b0; req_valid = 0; done_valid = 0; rfsh_hit_valid = 0;
    req_bank = '0; done_bank = '0; rfsh_hit_bank = '0;
    row_open = '0; rfsh_collide = '0; cmd_ready = 1'b1;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    for (int b = 0; b < NB; b++) check("R1 state", st_of(b), 0);
    check("R1 awake", int'(bank_awake), 15);
    check("R1 cmd_valid", int'(cmd_valid), 0);
    check("R1 reinit", int'(rfsh_reinit), 0);

    // R2 precharge power-down, then R4 escalation
    ev_req(0);
    check("R2 awake with work", st_of(0), 0);
    ev_done(0);
    check("R2 state pre", st_of(0), 3);
    cmd_is("R2 enter pre", 0, 1);
    tick();
    check("R2 accepted", int'(cmd_valid), 0);
    check("R9 asleep not awake", int'(bank_awake[0]), 0);
    repeat (IDLE - 1) tick();
    check("R4 not yet", st_of(0), 3);
    tick();
    check("R4 self-refresh", st_of(0), 4);
    cmd_is("R4 enter sr", 0, 2);
    tick();

    // R6 exit self-refresh and R8 reinit pulse
    ev_req(0);
    check("R6 state awake", st_of(0), 0);
    cmd_is("R6 exit sr", 0, 5);
    check("R9 exit queued", int'(bank_awake[0]), 0);
    tick();
    check("R9 exit done", int'(bank_awake[0]), 1);
    for (int i = 1; i <= SRX - 2; i++) begin
      tick();
      check("R8 early", int'(rfsh_reinit[0]), 0);
    end
    tick();
    check("R8 pulse", int'(rfsh_reinit[0]), 1);
    tick();
    check("R8 single", int'(rfsh_reinit[0]), 0);

    // R3 collision veto
    row_open[0] = 1'b1; rfsh_collide[0] = 1'b1;
    ev_done(0);
    check("R3 state kept", st_of(0), 0);
    check("R3 no cmd", int'(cmd_valid), 0);
    rfsh_collide[0] = 1'b0;
    ev_req(0);
    ev_done(0);
    check("R2 state act", st_of(0), 2);
    cmd_is("R2 enter act", 0, 0);
    tick();

    // R7 refresh wake, R5 request after refresh
    ev_ref(0);
    check("R7 state rf", st_of(0), 1);
    cmd_is("R7 exit act", 0, 3);
    tick();
    check("R7 awake after exit", int'(bank_awake[0]), 1);
    ev_req(0);
    check("R5 state", st_of(0), 0);
    check("R5 no cmd", int'(cmd_valid), 0);
    ev_ref(1);
    check("R7 awake bank ignores", st_of(1), 0);
    check("R7 no cmd", int'(cmd_valid), 0);

    // R10 hold, R11 withdraw, R12 queue behind offered entry
    cmd_ready = 1'b0; row_open[0] = 1'b0; row_open[1] = 1'b0;
    ev_done(0);
    cmd_is("R10 offered", 0, 1);
    tick(); tick();
    cmd_is("R10 held", 0, 1);
    ev_req(1);
    ev_done(1);
    check("R11 bank1 down", st_of(1), 3);
    cmd_is("R10 priority lock", 0, 1);
    ev_req(1);
    check("R11 bank1 back", st_of(1), 0);
    check("R11 bank1 awake", int'(bank_awake[1]), 1);
    ev_req(0);
    check("R12 state", st_of(0), 0);
    check("R12 awake low", int'(bank_awake[0]), 0);
    cmd_is("R12 entry kept", 0, 1);
    cmd_ready = 1'b1;
    tick();
    cmd_is("R12 exit follows", 0, 4);
    tick();
    check("R11 nothing for bank1", int'(cmd_valid), 0);
    check("R12 awake", int'(bank_awake[0]), 1);

    // random phase against a physical-mode model
    for (int b = 0; b < NB; b++) begin phys[b] = 0; outst[b] = 0; end
    outst[0] = 1; outst[1] = 1;
    pv = 0; pr = 1; pb = 0; po = 0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (pv == 1 && pr == 0) begin
        check("R10 hold valid", int'(cmd_valid), 1);
        check("R10 hold bank", int'(cmd_bank), pb);
        check("R10 hold op", int'(cmd_op), po);
      end
      for (int b = 0; b < NB; b++)
        if (bank_awake[b]) check("R9 awake means out of power-down", phys[b], 0);
      req_valid = 0; done_valid = 0; rfsh_hit_valid = 0;
      if ($urandom_range(99) < 30) begin
        int b = int'($urandom_range(NB - 1));
        if (outst[b] < 10) begin req_valid = 1; req_bank = BW'(b); outst[b]++; end
      end
      if ($urandom_range(99) < 30) begin
        int b = int'($urandom_range(NB - 1));
        if (outst[b] > 0) begin done_valid = 1; done_bank = BW'(b); outst[b]--; end
      end
      if ($urandom_range(99) < 5) begin
        rfsh_hit_valid = 1; rfsh_hit_bank = BW'($urandom_range(NB - 1));
      end
      for (int b = 0; b < NB; b++) begin
        rfsh_collide[b] = ($urandom_range(9) == 0);
        row_open[b] = $urandom_range(1) == 1;
      end
      cmd_ready = ($urandom_range(9) < 6);
      if (cmd_valid && cmd_ready) begin
        int b = int'(cmd_bank);
        case (int'(cmd_op))
          0: begin check("R2 entry from awake", phys[b], 0); phys[b] = 1; end
          1: begin check("R2 entry from awake", phys[b], 0); phys[b] = 2; end
          2: begin check("R4 sr from power-down", int'(phys[b] == 1 || phys[b] == 2), 1); phys[b] = 3; end
          3: begin check("R6 exit matches active", phys[b], 1); phys[b] = 0; end
          4: begin check("R6 exit matches precharge", phys[b], 2); phys[b] = 0; end
          5: begin check("R6 exit matches sr", phys[b], 3); phys[b] = 0; end
          default: check("R10 legal op", int'(cmd_op), 0);
        endcase
      end
      pv = int'(cmd_valid); pr = int'(cmd_ready); pb = int'(cmd_bank); po = int'(cmd_op);
      tick();
    end
    req_valid = 0; done_valid = 0; rfsh_hit_valid = 0;
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule